// File: doc/BRIEF.md
# Dual Wiper Register Controller

This block is the register core behind a two-channel digital potentiometer. Each channel owns an 8-bit wiper register, whose value picks one of 256 tap positions, and a small bank of stored settings (four 8-bit entries per channel by default). The stored bank is held in a plain register array and stands in for nonvolatile cells. It keeps its contents through reset. The wiper registers do not.

The serial front end decodes each instruction and presents it as a one-cycle command strobe. It frames each transaction with the active-low select line. Reads answer one cycle after the command. Increments and decrements act at once. All other writes are held in one pending slot and applied when the select line rises. A write to the stored bank then starts a timed internal write, and the busy flag stays high while it runs. A write-protect input blocks writes to the stored bank but never blocks wiper changes. Dropping it before the commit cancels a pending stored write. Once the commit has happened, write-protect has no further effect on that write. When reset is released, entry 0 of each channel's bank is copied into that channel's wiper.

Top module: `dual_wiper_core`

## Requirements
- R1: While `rst_n` is low, `busy` is 1, `rd_valid` is 0 and both wipers read 0. On the first clock edge after release, `wiper0` loads stored entry 0 of channel 0 and `wiper1` loads stored entry 0 of channel 1, and `busy` falls. The stored entries keep their values across reset.
- R2: Opcode 1 (wiper write, `cmd_ch` selects the channel) loads `cmd_data` into the wiper on the clock edge that samples `cs_n` high after the transaction. `wp_n` has no effect on it, and `busy` stays low.
- R3: Opcode 0 (read wiper) and opcode 2 (read stored entry `cmd_idx`) return the value on `rd_data` with `rd_valid` high in the cycle after the command. A stored-entry read inside the transaction that wrote that entry returns the old value.
- R4: Opcode 3 (write `cmd_data` to stored entry `cmd_idx`) and opcode 4 (copy the wiper value, taken when the command is accepted, into stored entry `cmd_idx`) commit when `cs_n` rises. The commit holds `busy` high for exactly WR_CYCLES cycles, after which the entry holds the new value.
- R5: Opcode 5 copies stored entry `cmd_idx` into the channel's wiper when `cs_n` rises, with no busy period.
- R6: Opcode 6 raises and opcode 7 lowers the channel's wiper by one on the command's clock edge. The value saturates at 255 and at 0.
- R7: A stored write is dropped if `wp_n` is 0 when the command arrives. It is also dropped if `wp_n` is 0 in any later cycle with `cs_n` low, or in the cycle where `cs_n` is sampled high.
- R8: After a stored write has committed, `wp_n` changes do not stop it, and it does not move either wiper.
- R9: While `busy` is high, every command is ignored: no `rd_valid`, no wiper step, nothing pending.
- R10: When a transaction holds several write-class commands, only the last one is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| cs_n | input | 1 | Active-low transaction select; rising edge commits |
| wp_n | input | 1 | Active-low write protect for stored entries |
| cmd_valid | input | 1 | One-cycle decoded command strobe |
| cmd_op | input | 3 | Opcode 0..7 as listed in the requirements |
| cmd_ch | input | 1 | Channel select |
| cmd_idx | input | IW | Stored entry index |
| cmd_data | input | DW | Write data |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DW | Read result |
| wiper0 | output | DW | Channel 0 tap code |
| wiper1 | output | DW | Channel 1 tap code |
| busy | output | 1 | Recall or internal write in progress |

## Verification
The race of interest is a commit on the `cs_n` rising edge against a write-protect fall. The bench drops `wp_n` in the very cycle that `cs_n` rises. It expects no busy period and an unchanged stored entry, which it confirms by reading the entry back. It then drops `wp_n` one cycle after a commit. There it expects a full busy window of WR_CYCLES cycles and the new value in the entry. Together the two cases pin the cancel-or-commit boundary to a single clock edge.

// File: rtl/dual_wiper_core.sv
module dual_wiper_core #(
  parameter int DW = 8,
  parameter int NDR = 4,
  parameter int WR_CYCLES = 16,
  parameter int IW = (NDR > 1) ? $clog2(NDR) : 1,
  parameter logic [2*NDR*DW-1:0] DR_INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wp_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic          cmd_ch,
  input  logic [IW-1:0] cmd_idx,
  input  logic [DW-1:0] cmd_data,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] wiper0,
  output logic [DW-1:0] wiper1,
  output logic          busy
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  localparam int AW = IW + 1;
  localparam logic [DW-1:0] TOP = '1;
  localparam logic [DW-1:0] BOT = '0;
  localparam logic [CW-1:0] CYC = CW'(WR_CYCLES);
  localparam logic [CW-1:0] ONE = CW'(1);

  localparam logic [2:0] OP_RDW = 3'd0;
  localparam logic [2:0] OP_WRW = 3'd1;
  localparam logic [2:0] OP_RDD = 3'd2;
  localparam logic [2:0] OP_WRD = 3'd3;
  localparam logic [2:0] OP_STO = 3'd4;
  localparam logic [2:0] OP_RCL = 3'd5;
  localparam logic [2:0] OP_INC = 3'd6;
  localparam logic [2:0] OP_DEC = 3'd7;

  localparam logic [1:0] PK_NONE = 2'd0;
  localparam logic [1:0] PK_WIP  = 2'd1;
  localparam logic [1:0] PK_NV   = 2'd2;

  logic [DW-1:0] nvm [2*NDR];
  logic [DW-1:0] wip [2];
  logic          cs_q;
  logic          recall;
  logic [CW-1:0] cnt;
  logic [1:0]    pk;
  logic          pch;
  logic [IW-1:0] pidx;
  logic [DW-1:0] pval;
  logic [AW-1:0] nadr;
  logic [DW-1:0] nval;

  initial begin
    for (int k = 0; k < 2*NDR; k++) nvm[k] = DR_INIT[k*DW +: DW];
  end

  wire           busy_i  = recall | (cnt != '0);
  wire           cs_rise = cs_n & ~cs_q;
  wire           take    = cmd_valid & ~cs_n & ~busy_i;
  wire [DW-1:0]  dsel    = nvm[{cmd_ch, cmd_idx}];
  wire [DW-1:0]  wsel    = wip[cmd_ch];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      recall   <= 1'b1;
      cnt      <= '0;
      pk       <= PK_NONE;
      pch      <= 1'b0;
      pidx     <= '0;
      pval     <= '0;
      nadr     <= '0;
      nval     <= '0;
      wip[0]   <= '0;
      wip[1]   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      cs_q     <= cs_n;
      rd_valid <= 1'b0;
      if (recall) begin
        wip[0] <= nvm[{1'b0, {IW{1'b0}}}];
        wip[1] <= nvm[{1'b1, {IW{1'b0}}}];
        recall <= 1'b0;
      end
      if (cnt != '0) cnt <= cnt - ONE;
      if (cs_rise) begin
        if (pk == PK_WIP) begin
          wip[pch] <= pval;
        end else if (pk == PK_NV && wp_n) begin
          cnt  <= CYC;
          nadr <= {pch, pidx};
          nval <= pval;
        end
      end
      if (cs_n || (!wp_n && pk == PK_NV)) pk <= PK_NONE;
      if (take) begin
        case (cmd_op)
          OP_RDW: begin rd_data <= wsel; rd_valid <= 1'b1; end
          OP_RDD: begin rd_data <= dsel; rd_valid <= 1'b1; end
          OP_WRW: begin pk <= PK_WIP; pch <= cmd_ch; pval <= cmd_data; end
          OP_RCL: begin pk <= PK_WIP; pch <= cmd_ch; pval <= dsel; end
          OP_WRD: if (wp_n) begin
            pk <= PK_NV; pch <= cmd_ch; pidx <= cmd_idx; pval <= cmd_data;
          end
          OP_STO: if (wp_n) begin
            pk <= PK_NV; pch <= cmd_ch; pidx <= cmd_idx; pval <= wsel;
          end
          OP_INC: if (wsel != TOP) wip[cmd_ch] <= wsel + 1'b1;
          OP_DEC: if (wsel != BOT) wip[cmd_ch] <= wsel - 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && cnt == ONE) nvm[nadr] <= nval;
  end

  assign wiper0 = wip[0];
  assign wiper1 = wip[1];
  assign busy   = busy_i;
endmodule

// File: rtl/dual_wiper_core_chk.sv
module dual_wiper_core_chk #(
  parameter int DW = 8,
  parameter int IW = 2,
  parameter int WR_CYCLES = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          wp_n,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic          cmd_ch,
  input logic [IW-1:0] cmd_idx,
  input logic [DW-1:0] cmd_data,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic [DW-1:0] wiper0,
  input logic [DW-1:0] wiper1,
  input logic          busy
);
  logic [31:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else        run <= busy ? run + 32'd1 : 32'd0;
  end

  a_r1_recall_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> busy);

  a_r4_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run <= 32'(WR_CYCLES));

  a_r6_inc_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cs_n && !busy && cmd_op == 3'd6 && !cmd_ch && wiper0 == '1)
    |=> wiper0 == '1);

  a_r6_dec_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cs_n && !busy && cmd_op == 3'd7 && cmd_ch && wiper1 == '0)
    |=> wiper1 == '0);

  a_r8_commit_keeps_wipers: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($stable(wiper0) && $stable(wiper1)));

  a_r9_busy_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> !rd_valid);
endmodule

bind dual_wiper_core dual_wiper_core_chk #(.DW(DW), .IW(IW), .WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .cmd_ch(cmd_ch), .cmd_idx(cmd_idx), .cmd_data(cmd_data),
  .rd_valid(rd_valid), .rd_data(rd_data), .wiper0(wiper0), .wiper1(wiper1),
  .busy(busy)
);

// File: tb/dual_wiper_core_tb.sv
module dual_wiper_core_tb;
  localparam int PERIOD = 10;
  localparam int DW = 8;
  localparam int NDR = 4;
  localparam int IW = 2;
  localparam int WRC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic wp_n = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic cmd_ch = 1'b0;
  logic [IW-1:0] cmd_idx = '0;
  logic [DW-1:0] cmd_data = '0;
  logic rd_valid, busy;
  logic [DW-1:0] rd_data, wiper0, wiper1;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  dual_wiper_core #(.DW(DW), .NDR(NDR), .WR_CYCLES(WRC), .IW(IW),
                    .DR_INIT(64'h1716151413121110)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_ch(cmd_ch), .cmd_idx(cmd_idx), .cmd_data(cmd_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .wiper0(wiper0), .wiper1(wiper1),
    .busy(busy)
  );

  // {op, ch, idx, data, read op, expected}
  localparam int NV = 13;
  localparam logic [24:0] VEC [NV] = '{
    {3'd1, 1'b0, 2'd0, 8'h80, 3'd0, 8'h80},
    {3'd1, 1'b1, 2'd0, 8'hFE, 3'd0, 8'hFE},
    {3'd6, 1'b1, 2'd0, 8'h00, 3'd0, 8'hFF},
    {3'd6, 1'b1, 2'd0, 8'h00, 3'd0, 8'hFF},
    {3'd3, 1'b0, 2'd2, 8'hA5, 3'd2, 8'hA5},
    {3'd4, 1'b1, 2'd3, 8'h00, 3'd2, 8'hFF},
    {3'd5, 1'b0, 2'd2, 8'h00, 3'd0, 8'hA5},
    {3'd1, 1'b0, 2'd0, 8'h00, 3'd0, 8'h00},
    {3'd7, 1'b0, 2'd0, 8'h00, 3'd0, 8'h00},
    {3'd6, 1'b0, 2'd0, 8'h00, 3'd0, 8'h01},
    {3'd7, 1'b1, 2'd0, 8'h00, 3'd0, 8'hFE},
    {3'd5, 1'b1, 2'd1, 8'h00, 3'd0, 8'h15},
    {3'd3, 1'b1, 2'd0, 8'h3C, 3'd2, 8'h3C}
  };

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd1: return "R2";
      3'd3, 3'd4: return "R4";
      3'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic ch, input logic [IW-1:0] idx,
                     input logic [DW-1:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_ch = ch; cmd_idx = idx; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic open_txn;
    @(negedge clk);
    cs_n = 1'b0;
  endtask

  task automatic close_txn;
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
  endtask

  task automatic rd(input string tag, input logic [2:0] op, input logic ch,
                    input logic [IW-1:0] idx, input int exp);
    open_txn();
    cmd(op, ch, idx, '0);
    check(tag, rd_valid, 1);
    check(tag, rd_data, exp);
    close_txn();
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 1);
    check("R1 rd_valid in reset", rd_valid, 0);
    check("R1 wiper0 in reset", wiper0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 recall wiper0", wiper0, 8'h10);
    check("R1 recall wiper1", wiper1, 8'h14);
    check("R1 busy after recall", busy, 0);

    for (int i = 0; i < NV; i++) begin
      open_txn();
      cmd(VEC[i][24:22], VEC[i][21], VEC[i][20:19], VEC[i][18:11]);
      close_txn();
      wait_idle();
      rd(tag_of(VEC[i][24:22]), VEC[i][10:8], VEC[i][21], VEC[i][20:19], VEC[i][7:0]);
    end

    // R3: old stored value visible before commit
    open_txn();
    cmd(3'd3, 1'b0, 2'd1, 8'h77);
    cmd(3'd2, 1'b0, 2'd1, 8'h00);
    check("R3 read old in txn", rd_data, 8'h11);
    close_txn();
    wait_idle();
    rd("R4 write after txn", 3'd2, 1'b0, 2'd1, 8'h77);

    // R2: wiper write under write protect
    wp_n = 1'b0;
    open_txn();
    cmd(3'd1, 1'b0, 2'd0, 8'h42);
    close_txn();
    check("R2 wiper under wp", wiper0, 8'h42);
    check("R2 no busy", busy, 0);

    // R7: stored write rejected at command
    open_txn();
    cmd(3'd3, 1'b0, 2'd3, 8'h99);
    close_txn();
    check("R7 rejected no busy", busy, 0);
    wp_n = 1'b1;
    rd("R7 rejected entry", 3'd2, 1'b0, 2'd3, 8'h13);

    // R7: cancel mid-transaction
    open_txn();
    cmd(3'd3, 1'b0, 2'd3, 8'h55);
    wp_n = 1'b0;
    @(negedge clk);
    wp_n = 1'b1;
    close_txn();
    check("R7 cancel no busy", busy, 0);
    rd("R7 cancel entry", 3'd2, 1'b0, 2'd3, 8'h13);

    // R7: wp falls on the cs rising cycle
    open_txn();
    cmd(3'd3, 1'b1, 2'd2, 8'h66);
    wp_n = 1'b0;
    close_txn();
    check("R7 same-cycle no busy", busy, 0);
    wp_n = 1'b1;
    rd("R7 same-cycle entry", 3'd2, 1'b1, 2'd2, 8'h16);

    // R8 and R4: wp falls after commit, busy length
    open_txn();
    cmd(3'd3, 1'b1, 2'd2, 8'h66);
    close_txn();
    wp_n = 1'b0;
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    check("R4 busy length", n, WRC);
    wp_n = 1'b1;
    rd("R8 write completes", 3'd2, 1'b1, 2'd2, 8'h66);

    // R9: commands ignored while busy
    open_txn();
    cmd(3'd3, 1'b0, 2'd0, 8'h5A);
    close_txn();
    check("R9 busy started", busy, 1);
    open_txn();
    cmd(3'd0, 1'b0, 2'd0, 8'h00);
    check("R9 read ignored", rd_valid, 0);
    cmd(3'd6, 1'b0, 2'd0, 8'h00);
    close_txn();
    check("R9 inc ignored", wiper0, 8'h42);
    wait_idle();
    rd("R9 write landed", 3'd2, 1'b0, 2'd0, 8'h5A);

    // R10: last write wins
    open_txn();
    cmd(3'd1, 1'b0, 2'd0, 8'h11);
    cmd(3'd1, 1'b0, 2'd0, 8'h22);
    close_txn();
    check("R10 last wins", wiper0, 8'h22);

    // R1: stored entries survive reset
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 wiper1 in reset", wiper1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 recall kept wiper0", wiper0, 8'h5A);
    check("R1 recall kept wiper1", wiper1, 8'h3C);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule